// File: doc/BRIEF.md
# Memory Address Generation Unit

This block forms the effective address of a load or store. Each request carries an addressing-mode code together with the values already read from the register file: a base register, an index register, the program counter, a displacement from the instruction, a scale code and an access-size code. The block adds them according to the mode and returns the effective address. For the four automodification modes it also returns a new base value and a write-enable for the register file.

For memory-indirect addressing the block works in two steps. The first request produces the address of a pointer and raises a second-reference flag. The surrounding pipeline fetches the pointer from memory and sends it back on the pointer input. The block then returns that pointer plus the displacement as the final address.

All arithmetic is combinational. A single register stage follows it, so results appear one clock after a request. Address sums wrap modulo 2^32 and no fault is raised.

Top module: `agu_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_vld`, `out_ea`, `out_wb_en`, `out_wb_val` and `out_ind_req` are all zero.
- R2: Modes 0 (absolute), 1 (register indirect), 2 (base plus displacement) and 3 (PC-relative) give `disp`, `base`, `base+disp` and `pc+disp` respectively.
- R3: Mode 4 (absolute indexed) gives `disp + index*2^s` and mode 5 (register indexed) gives `base + disp + index*2^s`, where `s` is the scale code.
- R4: Scale codes 0..4 select shifts of 0..4 bits (factors 1, 2, 4, 8, 16). Codes 5, 6 and 7 behave as code 4.
- R5: Mode 6 (pre-increment) and mode 7 (pre-decrement) give an address equal to the updated base, `base+n` or `base-n`, where `n` is the access size in bytes. That same value is the write-back.
- R6: Mode 8 (post-increment) and mode 9 (post-decrement) give `base` as the address and `base+n` or `base-n` as the write-back.
- R7: Size code 0, 1, 2 and 3 means `n` = 1, 2, 4 and 8 bytes.
- R8: `out_wb_en` is high only for modes 6 to 9. `out_wb_val` is zero whenever `out_wb_en` is low.
- R9: Mode 10 (memory-indirect) gives `base+disp` as the pointer address, raises `out_ind_req`, and does not write back.
- R10: When `ptr_vld` is high, the result is `ptr_data + disp` with `out_ind_req` and `out_wb_en` low. This takes priority over any request on `in_vld` in the same cycle.
- R11: All address and write-back sums wrap modulo 2^32.
- R12: Mode codes 11 to 15 behave as register indirect: the address is `base`, with no write-back and no second-reference request.
- R13: The outputs are registered. `out_vld` is high exactly one cycle after a cycle in which `in_vld` or `ptr_vld` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Address request valid |
| mode | input | 4 | Addressing-mode code |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| pc | input | 32 | Program counter of the instruction |
| disp | input | 32 | Displacement (absolute address in mode 0) |
| scale | input | 3 | Scale code (shift amount) |
| size | input | 2 | Access-size code |
| ptr_vld | input | 1 | Fetched pointer for the indirect second step is valid |
| ptr_data | input | 32 | Fetched pointer value |
| out_vld | output | 1 | Registered result valid |
| out_ea | output | 32 | Effective address |
| out_wb_en | output | 1 | Base register write-back enable |
| out_wb_val | output | 32 | New base register value |
| out_ind_req | output | 1 | Request for a second memory reference |

## Verification
The assertions assume that `in_vld`, `ptr_vld` and `mode` are low or known on the cycle `rst` falls, because several checks compare against the previous cycle's request. They also assume that the mode is stable within a request cycle. The stimulus meets both assumptions. It holds every valid input low throughout reset and drives each request on the falling edge for exactly one cycle. Operands are chosen to cross zero and the 2^32 boundary, so that the wrap cases are exercised rather than assumed.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int ADDR_W       = 32;
    localparam int SCALE_MAX_SH = 4;

    typedef enum logic [3:0] {
        AM_ABS      = 4'd0,
        AM_REG      = 4'd1,
        AM_REG_DISP = 4'd2,
        AM_PC_REL   = 4'd3,
        AM_IDX_ABS  = 4'd4,
        AM_IDX_REG  = 4'd5,
        AM_PRE_INC  = 4'd6,
        AM_PRE_DEC  = 4'd7,
        AM_POST_INC = 4'd8,
        AM_POST_DEC = 4'd9,
        AM_MEM_IND  = 4'd10
    } am_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic              wb_en;
        logic [ADDR_W-1:0] wb_val;
        logic              ind_req;
    } agu_res_t;

    function automatic logic is_automod(input logic [3:0] m);
        return (m >= 4'(AM_PRE_INC)) && (m <= 4'(AM_POST_DEC));
    endfunction

    function automatic logic is_decrement(input logic [3:0] m);
        return (m == 4'(AM_PRE_DEC)) || (m == 4'(AM_POST_DEC));
    endfunction

    function automatic logic [ADDR_W-1:0] size_bytes(input logic [1:0] code);
        return {{(ADDR_W-4){1'b0}}, 4'b0001 << code};
    endfunction

endpackage

// File: rtl/agu_scaler.sv
module agu_scaler
    import agu_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int MAX_SH = SCALE_MAX_SH,
    parameter int CW     = 3
) (
    input  logic [AW-1:0] index,
    input  logic [CW-1:0] code,
    output logic [AW-1:0] scaled
);
    localparam int NSH = MAX_SH + 1;

    logic [AW-1:0] cand [NSH];
    logic [CW-1:0] sh;

    genvar k;
    generate
        for (k = 0; k < NSH; k++) begin : g_shift
            assign cand[k] = index << k;
        end
    endgenerate

    always_comb begin
        sh = (code > CW'(MAX_SH)) ? CW'(MAX_SH) : code;
        scaled = '0;
        for (int i = 0; i < NSH; i++) begin
            if (sh == CW'(i)) scaled = cand[i];
        end
    end
endmodule

// File: rtl/agu_automod.sv
module agu_automod
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    size,
    input  logic          dec,
    output logic [AW-1:0] next_base
);
    logic [AW-1:0] step;

    always_comb begin
        step      = size_bytes(size);
        next_base = dec ? (base - step) : (base + step);
    end
endmodule

// File: rtl/agu_addr_sel.sv
module agu_addr_sel
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] scaled,
    input  logic [AW-1:0] next_base,
    input  logic          ptr_vld,
    input  logic [AW-1:0] ptr_data,
    output agu_res_t      res
);
    logic [AW-1:0] base_disp;

    always_comb begin
        base_disp   = base + disp;
        res         = '0;
        res.wb_en   = 1'b0;
        res.ind_req = 1'b0;
        if (ptr_vld) begin
            res.ea = ptr_data + disp;
        end else begin
            case (mode)
                4'(AM_ABS):      res.ea = disp;
                4'(AM_REG):      res.ea = base;
                4'(AM_REG_DISP): res.ea = base_disp;
                4'(AM_PC_REL):   res.ea = pc + disp;
                4'(AM_IDX_ABS):  res.ea = disp + scaled;
                4'(AM_IDX_REG):  res.ea = base_disp + scaled;
                4'(AM_PRE_INC), 4'(AM_PRE_DEC): begin
                    res.ea     = next_base;
                    res.wb_en  = 1'b1;
                    res.wb_val = next_base;
                end
                4'(AM_POST_INC), 4'(AM_POST_DEC): begin
                    res.ea     = base;
                    res.wb_en  = 1'b1;
                    res.wb_val = next_base;
                end
                4'(AM_MEM_IND): begin
                    res.ea      = base_disp;
                    res.ind_req = 1'b1;
                end
                default:         res.ea = base;
            endcase
        end
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] disp,
    input  logic [2:0]    scale,
    input  logic [1:0]    size,
    input  logic          ptr_vld,
    input  logic [AW-1:0] ptr_data,
    output logic          out_vld,
    output logic [AW-1:0] out_ea,
    output logic          out_wb_en,
    output logic [AW-1:0] out_wb_val,
    output logic          out_ind_req
);
    logic [AW-1:0] scaled;
    logic [AW-1:0] next_base;
    agu_res_t      res_c;
    agu_res_t      res_q;
    logic          vld_q;

    agu_scaler #(.AW(AW), .MAX_SH(SCALE_MAX_SH), .CW(3)) u_scaler (
        .index  (index),
        .code   (scale),
        .scaled (scaled)
    );

    agu_automod #(.AW(AW)) u_automod (
        .base      (base),
        .size      (size),
        .dec       (is_decrement(mode)),
        .next_base (next_base)
    );

    agu_addr_sel #(.AW(AW)) u_sel (
        .mode      (mode),
        .base      (base),
        .pc        (pc),
        .disp      (disp),
        .scaled    (scaled),
        .next_base (next_base),
        .ptr_vld   (ptr_vld),
        .ptr_data  (ptr_data),
        .res       (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_vld | ptr_vld;
            res_q <= (in_vld | ptr_vld) ? res_c : '0;
        end
    end

    assign out_vld     = vld_q;
    assign out_ea      = res_q.ea;
    assign out_wb_en   = res_q.wb_en;
    assign out_wb_val  = res_q.wb_val;
    assign out_ind_req = res_q.ind_req;

    // R8
    wb_only_automod_chk: assert property (@(posedge clk) disable iff (rst)
        out_wb_en |-> ($past(in_vld) && !$past(ptr_vld) && is_automod($past(mode))));

    // R8
    wb_val_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_wb_en |-> (out_wb_val == '0));

    // R9
    ind_only_mem_chk: assert property (@(posedge clk) disable iff (rst)
        out_ind_req |-> ($past(in_vld) && !$past(ptr_vld) && $past(mode) == 4'(AM_MEM_IND)));

    // R10
    ptr_no_side_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_vld |=> (!out_ind_req && !out_wb_en && out_vld));

    // R6
    post_keeps_base_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !ptr_vld && (mode == 4'(AM_POST_INC) || mode == 4'(AM_POST_DEC)))
        |=> (out_ea == $past(base)));

    // R5
    pre_ea_is_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !ptr_vld && (mode == 4'(AM_PRE_INC) || mode == 4'(AM_PRE_DEC)))
        |=> (out_ea == out_wb_val && out_wb_en));

    // R13
    vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld == $past(in_vld || ptr_vld));
endmodule

// File: tb/agu_top_tb.sv
module agu_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [3:0]  mode = '0;
    logic [31:0] base = '0, index = '0, pc = '0, disp = '0, ptr_data = '0;
    logic [2:0]  scale = '0;
    logic [1:0]  size = '0;
    logic        ptr_vld = 1'b0;
    logic        out_vld, out_wb_en, out_ind_req;
    logic [31:0] out_ea, out_wb_val;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    agu_top u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .mode(mode), .base(base),
        .index(index), .pc(pc), .disp(disp), .scale(scale), .size(size),
        .ptr_vld(ptr_vld), .ptr_data(ptr_data), .out_vld(out_vld),
        .out_ea(out_ea), .out_wb_en(out_wb_en), .out_wb_val(out_wb_val),
        .out_ind_req(out_ind_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int m, input int sc);
        if (m <= 3) return "R2";
        if (m <= 5) return (sc > 4) ? "R4" : "R3";
        if (m <= 7) return "R5";
        if (m <= 9) return "R6";
        if (m == 10) return "R9";
        return "R12";
    endfunction

    task automatic one_req(input int m, input int sz, input int sc,
                           input logic [31:0] b, input logic [31:0] ix,
                           input logic [31:0] p, input logic [31:0] d);
        logic [31:0] n, sf, e_ea, e_wb;
        logic        e_wen, e_ind;
        string       t;
        n  = 32'd1 << sz;
        sf = index_scale(ix, sc);
        e_wen = 1'b0; e_ind = 1'b0; e_wb = 32'd0;
        case (m)
            0: e_ea = d;
            1: e_ea = b;
            2: e_ea = b + d;
            3: e_ea = p + d;
            4: e_ea = d + sf;
            5: e_ea = b + d + sf;
            6: begin e_ea = b + n; e_wb = b + n; e_wen = 1'b1; end
            7: begin e_ea = b - n; e_wb = b - n; e_wen = 1'b1; end
            8: begin e_ea = b; e_wb = b + n; e_wen = 1'b1; end
            9: begin e_ea = b; e_wb = b - n; e_wen = 1'b1; end
            10: begin e_ea = b + d; e_ind = 1'b1; end
            default: e_ea = b;
        endcase
        @(negedge clk);
        in_vld = 1'b1; mode = 4'(m); size = 2'(sz); scale = 3'(sc);
        base = b; index = ix; pc = p; disp = d;
        @(negedge clk);
        in_vld = 1'b0;
        t = tag_of(m, sc);
        chk({t, " ea"}, out_ea, e_ea);
        chk("R8 wb_en", {31'd0, out_wb_en}, {31'd0, e_wen});
        chk((m >= 6 && m <= 9) ? "R7 wb_val" : "R8 wb_val", out_wb_val, e_wb);
        chk("R9 ind_req", {31'd0, out_ind_req}, {31'd0, e_ind});
        chk("R13 vld", {31'd0, out_vld}, 32'd1);
    endtask

    function automatic logic [31:0] index_scale(input logic [31:0] ix, input int sc);
        int s;
        s = (sc > 4) ? 4 : sc;
        return ix * (2 ** s);
    endfunction

    initial begin
        logic [31:0] bv [3];
        logic [31:0] iv [3];
        logic [31:0] pv [3];
        logic [31:0] dv [3];
        bv = '{32'h0000_1000, 32'h0000_0000, 32'hFFFF_FFFC};
        iv = '{32'h0000_0003, 32'hFFFF_FFFF, 32'h1234_5678};
        pv = '{32'h0040_0000, 32'hFFFF_FFF0, 32'h0000_0010};
        dv = '{32'h0000_0020, 32'h0000_0020, 32'hFFFF_FFF8};

        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        chk("R1 vld", {31'd0, out_vld}, 32'd0);
        chk("R1 ea", out_ea, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 wb_en", {31'd0, out_wb_en}, 32'd0);
        chk("R1 ind", {31'd0, out_ind_req}, 32'd0);

        for (int p = 0; p < 3; p++)
            for (int m = 0; m < 16; m++)
                for (int sz = 0; sz < 4; sz++)
                    for (int sc = 0; sc < 8; sc++)
                        one_req(m, sz, sc, bv[p], iv[p], pv[p], dv[p]);

        // R13: idle cycle gives no valid
        @(negedge clk);
        chk("R13 idle", {31'd0, out_vld}, 32'd0);

        // R10: pointer step, alone and colliding with a request
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            ptr_vld = 1'b1; ptr_data = 32'hFFFF_FFF0; disp = 32'h0000_0018;
            in_vld = (k == 1); mode = 4'd6; base = 32'h100; size = 2'd2;
            @(negedge clk);
            ptr_vld = 1'b0; in_vld = 1'b0;
            chk("R10 ea (R11 wrap)", out_ea, 32'h0000_0008);
            chk("R10 ind", {31'd0, out_ind_req}, 32'd0);
            chk("R10 wb_en", {31'd0, out_wb_en}, 32'd0);
            chk("R10 vld", {31'd0, out_vld}, 32'd1);
        end

        // R11: predecrement below zero
        one_req(7, 3, 0, 32'h0000_0004, 32'd0, 32'd0, 32'd0);
        chk("R11 wrap", out_wb_val, 32'hFFFF_FFFC);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule